// File: doc/BRIEF.md
# Dual Accumulator Arithmetic Unit

This block is the integer arithmetic datapath for a pair of 40-bit signed accumulators. Each accumulator is seen as an 8-bit top part, a 16-bit middle word and a 16-bit bottom word. The block decodes one 16-bit operation word per cycle. Its sources are the two accumulators, two 32-bit secondary registers (each a high and a low 16-bit half), a 40-bit product value and immediates. It writes the result into the chosen accumulator and updates a zero, a sign and an overflow flag. Logic and shift operations are handled elsewhere, as are fetch, the multiplier and memory.

Many sources are aligned to the middle word. An 8-bit or 16-bit immediate, or a 16-bit secondary half, is sign-extended and moved up by 16 bits before use. Two operations take a second 16-bit word. The second word arrives later on its own strobed port, and the unit holds the first word until it comes. Compare and test operations change the flags only.

Top module: `dual_acc_alu`

## Requirements
- R1: After reset both accumulators and all three flags read zero.
- R2: Opcode bits [15:9]=0100110 writes acc0+acc1 into the accumulator chosen by bit 8. Opcode bits [15:9]=0101110 writes acc[d] minus acc[1-d] into acc[d], where d is bit 8. Results wrap modulo 2^40.
- R3: Opcode bits [15:11]=01000 adds a secondary half to acc[d], and 01010 subtracts one. The half is chosen by bits [10:9]: 0 is sec0 low, 1 is sec1 low, 2 is sec0 high, 3 is sec1 high. It is sign-extended and shifted left by 16.
- R4: Opcode bits [15:11]=01100 loads the same aligned half into acc[d]. The bottom 16 bits become zero and the overflow flag is cleared.
- R5: Opcode bits [15:9]=0000010 adds the sign-extended bits [7:0], shifted left by 16, to acc[d]. Bits 0000011 perform the same subtraction but set the flags only.
- R6: Opcode bits [15:9] of 0111011 and 0111101 add or subtract 1. Bits 0111010 and 0111100 add or subtract 0x10000.
- R7: Opcode bits [15:9]=0100111 adds the product input to acc[d], and 0101111 subtracts it.
- R8: Bits [15:9]=0111110 negates acc[d]. Bits 0110110 copies acc[1-d] into acc[d]. Bits [15:8]=1000r001 clears acc[r], with r in bit 11.
- R9: Opcode 0000001d 00000000 adds, and 0000001d 10000000 compares (flags only), the next strobed 16-bit immediate, sign-extended and shifted left by 16, against acc[d]. The immediate must come on a later cycle than the opcode. While the unit waits, new operation words are ignored. An immediate strobe with nothing pending is ignored.
- R10: The zero flag is set when all 40 result bits are zero. The sign flag equals result bit 39. The overflow flag is set on signed overflow of the 40-bit add or subtract.
- R11: An operation word that matches no listed encoding leaves the accumulators and flags unchanged.
- R12: Bits [15:8]=1011r001 sets the flags from acc[r], and opcode 0x82xx sets the flags from acc0-acc1. Neither writes an accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation word strobe |
| op_word | input | 16 | Operation word |
| imm_valid | input | 1 | Second-word strobe |
| imm_word | input | 16 | Second word (16-bit immediate) |
| sec0 | input | 32 | Secondary register 0, high half in [31:16] |
| sec1 | input | 32 | Secondary register 1, high half in [31:16] |
| prod | input | 40 | Product value |
| acc0 | output | 40 | Accumulator 0 |
| acc1 | output | 40 | Accumulator 1 |
| flag_zero | output | 1 | Zero flag |
| flag_sign | output | 1 | Sign flag |
| flag_ovf | output | 1 | Overflow flag |

## Verification
Signed overflow out of bit 39 is the hardest case to reach. Every aligned immediate or half is within ±2^31, so ordinary operations would need many steps to get near the 40-bit limits. The stimulus drives the product port at full width to load the largest positive value and then increments it to wrap to the most negative value. It then negates that value, which must overflow again, and subtracts a large product. A second hard case is the window between a two-word opcode and its immediate. The stimulus issues an operation word and a stray immediate inside that window before the real immediate arrives.

// File: rtl/dual_acc_pkg.sv
package dual_acc_pkg;
  localparam int OPC_W = 16;

  typedef enum logic [1:0] {ASEL_ACCD, ASEL_ACC0, ASEL_ZERO} asel_e;

  typedef enum logic [3:0] {
    BSEL_ZERO, BSEL_OTHER, BSEL_ACC1, BSEL_ACCD, BSEL_SEC,
    BSEL_PROD, BSEL_IMM8, BSEL_IMM16, BSEL_ONE, BSEL_MID
  } bsel_e;

  typedef struct packed {
    asel_e asel;
    bsel_e bsel;
    logic  sub;
    logic  wr;
    logic  dst;
  } ctl_t;

  typedef struct packed {
    logic       legal;
    logic       two_word;
    logic [1:0] sec_idx;
    ctl_t       ctl;
  } dec_t;
endpackage

// File: rtl/dual_acc_decode.sv
module dual_acc_decode
  import dual_acc_pkg::*;
(
  input  logic [OPC_W-1:0] op_i,
  output dec_t             dec_o
);
  always_comb begin
    dec_o          = '0;
    dec_o.legal    = 1'b1;
    dec_o.sec_idx  = op_i[10:9];
    dec_o.ctl.dst  = op_i[8];
    dec_o.ctl.wr   = 1'b1;
    dec_o.ctl.asel = ASEL_ACCD;
    dec_o.ctl.bsel = BSEL_ZERO;
    casez (op_i[15:8])
      8'b0100_0???: dec_o.ctl.bsel = BSEL_SEC;
      8'b0101_0???: begin dec_o.ctl.bsel = BSEL_SEC; dec_o.ctl.sub = 1'b1; end
      8'b0110_0???: begin dec_o.ctl.asel = ASEL_ZERO; dec_o.ctl.bsel = BSEL_SEC; end
      8'b0100_110?: begin dec_o.ctl.asel = ASEL_ACC0; dec_o.ctl.bsel = BSEL_ACC1; end
      8'b0101_110?: begin dec_o.ctl.bsel = BSEL_OTHER; dec_o.ctl.sub = 1'b1; end
      8'b0100_111?: dec_o.ctl.bsel = BSEL_PROD;
      8'b0101_111?: begin dec_o.ctl.bsel = BSEL_PROD; dec_o.ctl.sub = 1'b1; end
      8'b0000_010?: dec_o.ctl.bsel = BSEL_IMM8;
      8'b0000_011?: begin
        dec_o.ctl.bsel = BSEL_IMM8; dec_o.ctl.sub = 1'b1; dec_o.ctl.wr = 1'b0;
      end
      8'b0111_010?: dec_o.ctl.bsel = BSEL_MID;
      8'b0111_011?: dec_o.ctl.bsel = BSEL_ONE;
      8'b0111_100?: begin dec_o.ctl.bsel = BSEL_MID; dec_o.ctl.sub = 1'b1; end
      8'b0111_101?: begin dec_o.ctl.bsel = BSEL_ONE; dec_o.ctl.sub = 1'b1; end
      8'b0111_110?: begin
        dec_o.ctl.asel = ASEL_ZERO; dec_o.ctl.bsel = BSEL_ACCD; dec_o.ctl.sub = 1'b1;
      end
      8'b0110_110?: begin dec_o.ctl.asel = ASEL_ZERO; dec_o.ctl.bsel = BSEL_OTHER; end
      8'b1000_?001: begin dec_o.ctl.asel = ASEL_ZERO; dec_o.ctl.dst = op_i[11]; end
      8'b1011_?001: begin dec_o.ctl.wr = 1'b0; dec_o.ctl.dst = op_i[11]; end
      8'b1000_0010: begin
        dec_o.ctl.asel = ASEL_ACC0; dec_o.ctl.bsel = BSEL_ACC1;
        dec_o.ctl.sub  = 1'b1;      dec_o.ctl.wr   = 1'b0;
      end
      8'b0000_001?: begin
        dec_o.two_word = 1'b1;
        dec_o.ctl.bsel = BSEL_IMM16;
        if (op_i[7:0] == 8'h80) begin
          dec_o.ctl.sub = 1'b1;
          dec_o.ctl.wr  = 1'b0;
        end else if (op_i[7:0] != 8'h00) begin
          dec_o.legal    = 1'b0;
          dec_o.two_word = 1'b0;
        end
      end
      default: dec_o.legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/dual_acc_operand.sv
module dual_acc_operand
  import dual_acc_pkg::*;
#(
  parameter int ACC_W  = 40,
  parameter int WORD_W = 16
) (
  input  asel_e               asel_i,
  input  bsel_e               bsel_i,
  input  logic                dst_i,
  input  logic [1:0]          sec_idx_i,
  input  logic [ACC_W-1:0]    acc0_i,
  input  logic [ACC_W-1:0]    acc1_i,
  input  logic [2*WORD_W-1:0] sec0_i,
  input  logic [2*WORD_W-1:0] sec1_i,
  input  logic [ACC_W-1:0]    prod_i,
  input  logic [7:0]          short_i,
  input  logic [WORD_W-1:0]   long_i,
  output logic [ACC_W-1:0]    a_o,
  output logic [ACC_W-1:0]    b_o
);
  localparam int EXT_W = ACC_W - 2*WORD_W;
  localparam int NHALF = 4;

  function automatic logic [ACC_W-1:0] at_mid(input logic [WORD_W-1:0] w);
    return {{EXT_W{w[WORD_W-1]}}, w, {WORD_W{1'b0}}};
  endfunction

  logic [WORD_W-1:0] half [NHALF];
  for (genvar k = 0; k < NHALF; k++) begin : g_half
    localparam int HI_OFF = (k / 2) * WORD_W;
    if (k % 2 == 0) begin : g_src0
      assign half[k] = sec0_i[HI_OFF +: WORD_W];
    end else begin : g_src1
      assign half[k] = sec1_i[HI_OFF +: WORD_W];
    end
  end

  logic [ACC_W-1:0]  acc_d, acc_x, unit;
  logic [WORD_W-1:0] short_w;

  always_comb begin
    acc_d   = dst_i ? acc1_i : acc0_i;
    acc_x   = dst_i ? acc0_i : acc1_i;
    unit    = {{(ACC_W-1){1'b0}}, 1'b1};
    short_w = {{(WORD_W-8){short_i[7]}}, short_i};
    case (asel_i)
      ASEL_ACCD: a_o = acc_d;
      ASEL_ACC0: a_o = acc0_i;
      default:   a_o = '0;
    endcase
    case (bsel_i)
      BSEL_OTHER: b_o = acc_x;
      BSEL_ACC1:  b_o = acc1_i;
      BSEL_ACCD:  b_o = acc_d;
      BSEL_SEC:   b_o = at_mid(half[sec_idx_i]);
      BSEL_PROD:  b_o = prod_i;
      BSEL_IMM8:  b_o = at_mid(short_w);
      BSEL_IMM16: b_o = at_mid(long_i);
      BSEL_ONE:   b_o = unit;
      BSEL_MID:   b_o = unit << WORD_W;
      default:    b_o = '0;
    endcase
  end
endmodule

// File: rtl/dual_acc_addsub.sv
module dual_acc_addsub #(
  parameter int ACC_W = 40
) (
  input  logic [ACC_W-1:0] a_i,
  input  logic [ACC_W-1:0] b_i,
  input  logic             sub_i,
  output logic [ACC_W-1:0] sum_o,
  output logic             zero_o,
  output logic             sign_o,
  output logic             ovf_o
);
  localparam int MSB = ACC_W - 1;
  logic [ACC_W-1:0] b_eff;

  always_comb begin
    b_eff  = sub_i ? ~b_i : b_i;
    sum_o  = a_i + b_eff + {{(ACC_W-1){1'b0}}, sub_i};
    zero_o = (sum_o == '0);
    sign_o = sum_o[MSB];
    ovf_o  = (a_i[MSB] == b_eff[MSB]) && (sum_o[MSB] != a_i[MSB]);
  end
endmodule

// File: rtl/dual_acc_alu.sv
module dual_acc_alu
  import dual_acc_pkg::*;
#(
  parameter int ACC_W  = 40,
  parameter int WORD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                op_valid,
  input  logic [OPC_W-1:0]    op_word,
  input  logic                imm_valid,
  input  logic [WORD_W-1:0]   imm_word,
  input  logic [2*WORD_W-1:0] sec0,
  input  logic [2*WORD_W-1:0] sec1,
  input  logic [ACC_W-1:0]    prod,
  output logic [ACC_W-1:0]    acc0,
  output logic [ACC_W-1:0]    acc1,
  output logic                flag_zero,
  output logic                flag_sign,
  output logic                flag_ovf
);
  localparam int NACC = 2;

  // reset: asserted at once, released two clocks later
  logic [1:0] rst_sync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  dec_t dec;
  dual_acc_decode u_dec (.op_i(op_word), .dec_o(dec));

  logic pend_q, pend_d;
  ctl_t pend_ctl_q, pend_ctl_d;
  logic run_one, start_two, run_imm, exec;
  ctl_t ctl;

  always_comb begin
    run_one    = op_valid & ~pend_q & dec.legal & ~dec.two_word;
    start_two  = op_valid & ~pend_q & dec.legal &  dec.two_word;
    run_imm    = pend_q & imm_valid;
    exec       = run_one | run_imm;
    ctl        = run_imm ? pend_ctl_q : dec.ctl;
    pend_d     = start_two | (pend_q & ~imm_valid);
    pend_ctl_d = start_two ? dec.ctl : pend_ctl_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= 1'b0;
      pend_ctl_q <= '0;
    end else begin
      pend_q     <= pend_d;
      pend_ctl_q <= pend_ctl_d;
    end
  end

  logic [ACC_W-1:0] acc_q [NACC];
  logic [ACC_W-1:0] a_val, b_val, res;
  logic             res_z, res_s, res_v;

  dual_acc_operand #(.ACC_W(ACC_W), .WORD_W(WORD_W)) u_opnd (
    .asel_i(ctl.asel), .bsel_i(ctl.bsel), .dst_i(ctl.dst),
    .sec_idx_i(dec.sec_idx), .acc0_i(acc_q[0]), .acc1_i(acc_q[1]),
    .sec0_i(sec0), .sec1_i(sec1), .prod_i(prod),
    .short_i(op_word[7:0]), .long_i(imm_word),
    .a_o(a_val), .b_o(b_val)
  );

  dual_acc_addsub #(.ACC_W(ACC_W)) u_add (
    .a_i(a_val), .b_i(b_val), .sub_i(ctl.sub),
    .sum_o(res), .zero_o(res_z), .sign_o(res_s), .ovf_o(res_v)
  );

  for (genvar i = 0; i < NACC; i++) begin : g_acc
    logic             en;
    logic [ACC_W-1:0] q;
    assign en = exec & ctl.wr & (ctl.dst == 1'(i));
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni)  q <= '0;
      else if (en)  q <= res;
    end
    assign acc_q[i] = q;
  end

  logic [2:0] flags_q;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)    flags_q <= 3'b000;
    else if (exec)  flags_q <= {res_z, res_s, res_v};
  end

  assign acc0      = acc_q[0];
  assign acc1      = acc_q[1];
  assign flag_zero = flags_q[2];
  assign flag_sign = flags_q[1];
  assign flag_ovf  = flags_q[0];

  // unmatched words change nothing
  assert_undecoded_hold_R11: assert property (@(posedge clk) disable iff (!rst_ni)
    (op_valid && !pend_q && !dec.legal && !imm_valid)
      |=> ($stable(acc0) && $stable(acc1) && $stable(flags_q)));

  // compare and test ops leave both accumulators alone
  assert_flags_only_R12: assert property (@(posedge clk) disable iff (!rst_ni)
    (exec && !ctl.wr) |=> ($stable(acc0) && $stable(acc1)));

  // zero and sign flags agree with the accumulator just written
  assert_zero_flag_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    (exec && ctl.wr) |=> (flag_zero == (acc_q[$past(ctl.dst)] == '0)));
  assert_sign_flag_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    (exec && ctl.wr) |=> (flag_sign == acc_q[$past(ctl.dst)][ACC_W-1]));

  // register load clears the bottom word and the overflow flag
  assert_load_low_clear_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (run_one && ctl.asel == ASEL_ZERO && ctl.bsel == BSEL_SEC)
      |=> (acc_q[$past(ctl.dst)][WORD_W-1:0] == '0 && !flag_ovf));

  // while waiting for the second word nothing moves
  assert_wait_hold_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    (pend_q && !imm_valid) |=> ($stable(acc0) && $stable(acc1) && $stable(flags_q)));
endmodule

// File: tb/dual_acc_alu_test.sv
module dual_acc_alu_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [15:0] op_word = '0;
  logic        imm_valid = 1'b0;
  logic [15:0] imm_word = '0;
  logic [31:0] sec0 = 32'h8000_1234;
  logic [31:0] sec1 = 32'h7FFF_FFFE;
  logic [39:0] prod = '0;
  logic [39:0] acc0, acc1;
  logic        flag_zero, flag_sign, flag_ovf;

  always #2 clk = ~clk;

  dual_acc_alu uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_word(op_word),
    .imm_valid(imm_valid), .imm_word(imm_word), .sec0(sec0), .sec1(sec1),
    .prod(prod), .acc0(acc0), .acc1(acc1), .flag_zero(flag_zero),
    .flag_sign(flag_sign), .flag_ovf(flag_ovf)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  always @(posedge clk) cyc = cyc + 1;

  typedef struct {
    logic [39:0] e0;
    logic [39:0] e1;
    logic [2:0]  ef;
    int          due;
    string       tag;
  } item_t;
  item_t sb[$];

  // reference state
  logic [39:0] m_acc [2];
  logic        m_z, m_s, m_v;
  logic        m_pend, m_pd, m_pcmp;

  function automatic longint s40(input logic [39:0] x);
    return longint'($signed(x));
  endfunction

  function automatic longint mid16(input logic [15:0] w);
    longint t;
    t = longint'($signed(w));
    return t * 65536;
  endfunction

  function automatic logic [15:0] pick_half(input logic [1:0] k);
    logic [31:0] r;
    r = k[0] ? sec1 : sec0;
    return k[1] ? r[31:16] : r[15:0];
  endfunction

  task automatic model_apply(input longint a, input longint b, input bit sub,
                             input bit wr, input bit d);
    longint r;
    logic [39:0] t;
    r = sub ? (a - b) : (a + b);
    t = r[39:0];
    if (wr) m_acc[d] = t;
    m_z = (t == 40'd0);
    m_s = t[39];
    m_v = (r > 64'sd549755813887) || (r < -64'sd549755813888);
  endtask

  task automatic model_op(input logic [15:0] op);
    bit d;
    longint ad, ao;
    d  = op[8];
    ad = s40(m_acc[d]);
    ao = s40(m_acc[!d]);
    if (m_pend) return;
    casez (op[15:8])
      8'b0100_0???: model_apply(ad, mid16(pick_half(op[10:9])), 0, 1, d);
      8'b0101_0???: model_apply(ad, mid16(pick_half(op[10:9])), 1, 1, d);
      8'b0110_0???: model_apply(0, mid16(pick_half(op[10:9])), 0, 1, d);
      8'b0100_110?: model_apply(s40(m_acc[0]), s40(m_acc[1]), 0, 1, d);
      8'b0101_110?: model_apply(ad, ao, 1, 1, d);
      8'b0100_111?: model_apply(ad, s40(prod), 0, 1, d);
      8'b0101_111?: model_apply(ad, s40(prod), 1, 1, d);
      8'b0000_010?: model_apply(ad, mid16({{8{op[7]}}, op[7:0]}), 0, 1, d);
      8'b0000_011?: model_apply(ad, mid16({{8{op[7]}}, op[7:0]}), 1, 0, d);
      8'b0111_011?: model_apply(ad, 1, 0, 1, d);
      8'b0111_101?: model_apply(ad, 1, 1, 1, d);
      8'b0111_010?: model_apply(ad, 65536, 0, 1, d);
      8'b0111_100?: model_apply(ad, 65536, 1, 1, d);
      8'b0111_110?: model_apply(0, ad, 1, 1, d);
      8'b0110_110?: model_apply(0, ao, 0, 1, d);
      8'b1000_?001: model_apply(0, 0, 0, 1, op[11]);
      8'b1011_?001: model_apply(s40(m_acc[op[11]]), 0, 0, 0, op[11]);
      8'b1000_0010: model_apply(s40(m_acc[0]), s40(m_acc[1]), 1, 0, 0);
      8'b0000_001?: if (op[7:0] == 8'h00 || op[7:0] == 8'h80) begin
        m_pend = 1'b1; m_pd = d; m_pcmp = op[7];
      end
      default: ;
    endcase
  endtask

  task automatic push(input string tag);
    item_t it;
    it.e0 = m_acc[0]; it.e1 = m_acc[1]; it.ef = {m_z, m_s, m_v};
    it.due = cyc + 1; it.tag = tag;
    sb.push_back(it);
  endtask

  // driver: called at a falling edge, returns at the next one
  task automatic send_op(input logic [15:0] op, input string tag);
    op_word = op; op_valid = 1'b1;
    model_op(op);
    push(tag);
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic send_imm(input logic [15:0] w, input string tag);
    imm_word = w; imm_valid = 1'b1;
    if (m_pend) begin
      model_apply(s40(m_acc[m_pd]), mid16(w), m_pcmp, !m_pcmp, m_pd);
      m_pend = 1'b0;
    end
    push(tag);
    @(negedge clk);
    imm_valid = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    item_t it;
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      it = sb.pop_front();
      total++;
      if (acc0 !== it.e0 || acc1 !== it.e1 || {flag_zero, flag_sign, flag_ovf} !== it.ef) begin
        bad++;
        $display("FAIL %s actual acc0=%h acc1=%h zsv=%b expected acc0=%h acc1=%h zsv=%b",
                 it.tag, acc0, acc1, {flag_zero, flag_sign, flag_ovf}, it.e0, it.e1, it.ef);
      end
    end
  end

  initial begin
    repeat (40000) @(posedge clk);
    bad++;
    $display("FAIL watchdog (R1..all) actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    m_acc[0] = '0; m_acc[1] = '0;
    m_z = 0; m_s = 0; m_v = 0; m_pend = 0; m_pd = 0; m_pcmp = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    total++;
    if (acc0 !== '0 || acc1 !== '0 || {flag_zero, flag_sign, flag_ovf} !== 3'b000) begin
      bad++;
      $display("FAIL R1 reset actual acc0=%h acc1=%h zsv=%b expected all zero",
               acc0, acc1, {flag_zero, flag_sign, flag_ovf});
    end
    // clear and short immediates
    send_op(16'h8100, "R8 clear acc0");
    send_op(16'h8900, "R8 clear acc1");
    send_op(16'h0405, "R5 add imm8 +5 acc0");
    send_op(16'h05FF, "R5 add imm8 -1 acc1");
    send_op(16'h0680, "R5 compare imm8 acc0");
    // add and subtract between accumulators
    send_op(16'h4C00, "R2 add into acc0");
    send_op(16'h5D00, "R2 sub into acc1");
    send_op(16'h4D00, "R2 add into acc1");
    // secondary halves, all four selections
    send_op(16'h4000, "R3 add half 0");
    send_op(16'h4300, "R3 add half 1");
    send_op(16'h4400, "R3 add half 2");
    send_op(16'h4700, "R3 add half 3");
    send_op(16'h5600, "R3 sub half 3");
    send_op(16'h5300, "R3 sub half 1");
    // loads
    send_op(16'h6400, "R4 load half 2 acc0");
    send_op(16'h6300, "R4 load half 1 acc1");
    send_op(16'h6100, "R4 load half 0 acc1");
    // increments
    send_op(16'h7600, "R6 inc acc0");
    send_op(16'h7A00, "R6 dec acc0");
    send_op(16'h7400, "R6 mid inc acc0");
    send_op(16'h7900, "R6 mid dec acc1");
    send_op(16'h7B00, "R6 dec acc1");
    // product
    prod = 40'hFF_FFF0_0001;
    send_op(16'h4E00, "R7 add product acc0");
    send_op(16'h5F00, "R7 sub product acc1");
    // negate, move, test, compare
    send_op(16'h7C00, "R8 negate acc0");
    send_op(16'h6D00, "R8 move acc0 to acc1");
    send_op(16'h8200, "R10 compare equal zero flag");
    send_op(16'hB900, "R12 test acc1");
    send_op(16'h8100, "R8 clear acc0 again");
    send_op(16'hB100, "R12 test zero acc0");
    send_op(16'h8200, "R12 compare acc0 acc1");
    // overflow corners
    prod = 40'h7F_FFFF_FFFF;
    send_op(16'h4E00, "R7 load max via product");
    send_op(16'h7600, "R10 inc overflow wrap");
    send_op(16'h7C00, "R10 negate most negative");
    send_op(16'h5E00, "R10 sub product overflow");
    send_op(16'h7A00, "R6 dec from positive");
    // unmatched words
    send_op(16'h4800, "R11 unmatched 4800");
    send_op(16'hFFFF, "R11 unmatched FFFF");
    send_op(16'h0240, "R11 unmatched 0240");
    send_op(16'h7E00, "R11 unmatched 7E00");
    // two-word operations
    send_imm(16'h1111, "R9 stray immediate ignored");
    send_op(16'h0200, "R9 add long imm wait");
    send_op(16'h7600, "R9 op during wait ignored");
    @(negedge clk);
    send_imm(16'hFFFE, "R9 add long imm done");
    send_op(16'h0380, "R9 compare long imm wait");
    send_imm(16'h8000, "R9 compare long imm done");
    send_op(16'h0300, "R9 add long imm acc1 wait");
    send_imm(16'h7FFF, "R9 add long imm acc1 done");
    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule